// File: doc/BRIEF.md
# Dual-Edge Ramp Discharge Time Interpolator

This block holds the digital timing side of a stretch-type trigger interpolator for a sampled acquisition system. A trigger starts two analog ramps charging at the same moment and captures the acquisition memory pointer. Ramp A starts its slow discharge on the first rising edge of the sample clock after the trigger. Ramp B starts its slow discharge on the first falling edge. Each discharge is timed with the fast count clock until that ramp's comparator reports it empty. The length of each discharge encodes the interval from the trigger to the clock edge that started it.

The two start edges are half a sample period apart, assuming a 50% duty cycle. At most one of them can sit close to the trigger, so at least one channel gives a measurement clear of the near-coincidence region. A channel is rejected when its count is below a minimum or when it runs to a timeout. Channel A is preferred. A result from channel B is flagged so that downstream logic adds half a sample period. The sample clock is taken in as a level already synchronous to the count clock, and its edges are detected by comparing it with its value one count cycle earlier.

Top module: `dual_edge_interp`

## Requirements
- R1: After reset, both charge outputs, both drain outputs and `res_stb` are 0.
- R2: When `trig` is high in a cycle where both channels are idle, `charge_a` and `charge_b` go high in the next cycle, and `mem_ptr` from that cycle is kept as the pointer for the result.
- R3: Channel A leaves charging and raises `drain_a` in the cycle after the first count-clock cycle, following the trigger cycle, in which `smp_clk` is 1 and was 0 one cycle earlier.
- R4: Channel B does the same as R3 for `drain_b`, but on the first cycle in which `smp_clk` is 0 and was 1 one cycle earlier.
- R5: A channel's count is the number of its drain cycles in which its empty input was 0. The drain ends in the first drain cycle in which the empty input is 1.
- R6: A channel whose count is below `MIN_CNT` is invalid. A count equal to `MIN_CNT` is valid.
- R7: A channel whose count reaches `TMO_CNT` while its empty input is still 0 stops draining and is invalid. An empty input seen at a count of exactly `TMO_CNT` is still valid.
- R8: When both channels are valid, the result carries channel A's count and `res_chan_b` is 0.
- R9: When only channel B is valid, the result carries channel B's count and `res_chan_b` is 1. A value of 1 means half a sample period must be added.
- R10: When neither channel is valid, no strobe is produced and the block returns to idle.
- R11: `trig` is ignored while any channel is not idle. The reported pointer stays the one captured at the accepted trigger.
- R12: `res_stb` is a single-cycle pulse. It is asserted in the cycle after the last channel finishes, and the count, channel flag and pointer are valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_clk | input | 1 | Sample clock level, synchronous to clk |
| trig | input | 1 | Trigger event, one count cycle |
| mem_ptr | input | PW | Current acquisition memory pointer |
| empty_a | input | 1 | Comparator: ramp A discharged |
| empty_b | input | 1 | Comparator: ramp B discharged |
| charge_a | output | 1 | Ramp A charging |
| charge_b | output | 1 | Ramp B charging |
| drain_a | output | 1 | Ramp A slow discharge enabled |
| drain_b | output | 1 | Ramp B slow discharge enabled |
| res_stb | output | 1 | Result valid strobe |
| res_cnt | output | CW | Selected discharge count |
| res_chan_b | output | 1 | 1 when channel B is selected (half-period offset) |
| res_ptr | output | PW | Memory pointer captured at the trigger |

## Verification
The charge outputs are due one count cycle after the accepted trigger. Each drain output is due one cycle after the qualifying sample-clock edge. The strobe is due one cycle after the later channel finishes. The bench's behavioural model steps on the same clock edge as the design, from the same input values, and every output is compared at the falling edge that follows, so the cycle on which each result appears is checked exactly. Each shot also closes with a check of the captured result against a value computed directly from the two programmed discharge lengths, independently of the per-cycle model.

// File: rtl/dual_edge_interp.sv
module dual_edge_interp #(
  parameter int CW      = 16,
  parameter int PW      = 12,
  parameter int MIN_CNT = 4,
  parameter int TMO_CNT = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_clk,
  input  logic          trig,
  input  logic [PW-1:0] mem_ptr,
  input  logic          empty_a,
  input  logic          empty_b,
  output logic          charge_a,
  output logic          charge_b,
  output logic          drain_a,
  output logic          drain_b,
  output logic          res_stb,
  output logic [CW-1:0] res_cnt,
  output logic          res_chan_b,
  output logic [PW-1:0] res_ptr
);
  localparam logic [CW-1:0] MIN_V = CW'(MIN_CNT);
  localparam logic [CW-1:0] TMO_V = CW'(TMO_CNT);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DRAIN, S_DONE} st_t;

  st_t           st  [2];
  logic [CW-1:0] cnt [2];
  logic          ok  [2];
  logic          smp_q;
  logic [PW-1:0] ptr_q;

  wire rise = smp_clk & ~smp_q;
  wire fall = ~smp_clk & smp_q;
  wire [1:0] edge_hit = {fall, rise};
  wire [1:0] empty_v  = {empty_b, empty_a};
  wire all_idle  = (st[0] == S_IDLE) && (st[1] == S_IDLE);
  wire both_done = (st[0] == S_DONE) && (st[1] == S_DONE);
  wire accept    = trig & all_idle;

  assign charge_a = (st[0] == S_WAIT);
  assign charge_b = (st[1] == S_WAIT);
  assign drain_a  = (st[0] == S_DRAIN);
  assign drain_b  = (st[1] == S_DRAIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q      <= 1'b0;
      ptr_q      <= '0;
      res_stb    <= 1'b0;
      res_cnt    <= '0;
      res_chan_b <= 1'b0;
      res_ptr    <= '0;
      for (int i = 0; i < 2; i++) begin
        st[i]  <= S_IDLE;
        cnt[i] <= '0;
        ok[i]  <= 1'b0;
      end
    end else begin
      smp_q   <= smp_clk;
      res_stb <= 1'b0;
      if (accept) ptr_q <= mem_ptr;
      if (both_done) begin
        res_stb    <= ok[0] | ok[1];
        res_chan_b <= ~ok[0];
        res_cnt    <= ok[0] ? cnt[0] : cnt[1];
        res_ptr    <= ptr_q;
      end
      for (int i = 0; i < 2; i++) begin
        case (st[i])
          S_IDLE:  if (accept) st[i] <= S_WAIT;
          S_WAIT:  if (edge_hit[i]) begin
                     st[i]  <= S_DRAIN;
                     cnt[i] <= '0;
                   end
          S_DRAIN: if (empty_v[i]) begin
                     st[i] <= S_DONE;
                     ok[i] <= (cnt[i] >= MIN_V);
                   end else if (cnt[i] == TMO_V) begin
                     st[i] <= S_DONE;
                     ok[i] <= 1'b0;
                   end else begin
                     cnt[i] <= cnt[i] + 1'b1;
                   end
          default: if (both_done) st[i] <= S_IDLE;
        endcase
      end
    end
  end

  AST_TRIG_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (charge_a && charge_b)); // R2
  AST_A_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drain_a) |-> ($past(smp_clk) && !$past(smp_q))); // R3
  AST_B_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drain_b) |-> (!$past(smp_clk) && $past(smp_q))); // R4
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_a || drain_b) |-> (cnt[0] <= TMO_V && cnt[1] <= TMO_V)); // R7
  AST_MIN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_stb |-> (res_cnt >= MIN_V)); // R6
  AST_SINGLE_STB: assert property (@(posedge clk) disable iff (!rst_n)
    res_stb |=> !res_stb); // R12
  AST_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_idle && $past(!all_idle)) |-> $stable(ptr_q)); // R11
endmodule

// File: tb/test_dual_edge_interp.sv
module test_dual_edge_interp;
  localparam int CW = 16, PW = 12, MIN = 4, TMO = 200, H = 5;

  logic clk = 0, rst_n = 0, smp = 0, trig = 0, empty_a = 0, empty_b = 0;
  logic [PW-1:0] mem_ptr = '0;
  logic charge_a, charge_b, drain_a, drain_b, res_stb, res_chan_b;
  logic [CW-1:0] res_cnt;
  logic [PW-1:0] res_ptr;

  dual_edge_interp #(.CW(CW), .PW(PW), .MIN_CNT(MIN), .TMO_CNT(TMO)) i_dual_edge_interp (
    .clk(clk), .rst_n(rst_n), .smp_clk(smp), .trig(trig), .mem_ptr(mem_ptr),
    .empty_a(empty_a), .empty_b(empty_b), .charge_a(charge_a), .charge_b(charge_b),
    .drain_a(drain_a), .drain_b(drain_b), .res_stb(res_stb), .res_cnt(res_cnt),
    .res_chan_b(res_chan_b), .res_ptr(res_ptr));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, sc = 0;
  int tgt_a = 0, tgt_b = 0;
  int m_ph[2], m_cnt[2];
  bit m_ok[2];
  bit m_prev, e_stb, e_chan, rs, fl, idle, done, got, g_chan;
  int e_cnt, e_ptr, m_ptr, g_cnt, g_ptr;

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = '{0, 0}; m_cnt = '{0, 0}; m_ok = '{0, 0}; m_prev = 0; e_stb = 0;
    end else begin
      rs = smp && !m_prev; fl = !smp && m_prev; m_prev = smp;
      idle = (m_ph[0] == 0) && (m_ph[1] == 0);
      done = (m_ph[0] == 3) && (m_ph[1] == 3);
      e_stb = 0;
      if (done) begin
        e_stb = m_ok[0] || m_ok[1];
        e_chan = !m_ok[0];
        e_cnt = m_ok[0] ? m_cnt[0] : m_cnt[1];
        e_ptr = m_ptr;
        m_ph = '{0, 0};
      end else if (trig && idle) begin
        m_ptr = int'(mem_ptr);
        m_ph = '{1, 1};
      end else begin
        for (int i = 0; i < 2; i++) begin
          if (m_ph[i] == 1 && ((i == 0) ? rs : fl)) begin
            m_ph[i] = 2; m_cnt[i] = 0;
          end else if (m_ph[i] == 2) begin
            if ((i == 0) ? empty_a : empty_b) begin
              m_ph[i] = 3; m_ok[i] = (m_cnt[i] >= MIN);
            end else if (m_cnt[i] == TMO) begin
              m_ph[i] = 3; m_ok[i] = 0;
            end else m_cnt[i]++;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(charge_a == (m_ph[0] == 1), "R2 charge_a", charge_a, m_ph[0] == 1);
      chk(charge_b == (m_ph[1] == 1), "R2 charge_b", charge_b, m_ph[1] == 1);
      chk(drain_a == (m_ph[0] == 2), "R3 drain_a", drain_a, m_ph[0] == 2);
      chk(drain_b == (m_ph[1] == 2), "R4 drain_b", drain_b, m_ph[1] == 2);
      chk(res_stb == e_stb, "R12 res_stb", res_stb, e_stb);
      if (e_stb) begin
        chk(int'(res_cnt) == e_cnt, "R5 res_cnt", res_cnt, e_cnt);
        chk(res_chan_b == e_chan, "R8 res_chan_b", res_chan_b, e_chan);
        chk(int'(res_ptr) == e_ptr, "R11 res_ptr", res_ptr, e_ptr);
      end
      if (res_stb) begin
        got = 1; g_cnt = int'(res_cnt); g_chan = res_chan_b; g_ptr = int'(res_ptr);
      end
    end
    sc++;
    smp = (sc % (2 * H)) < H;
    empty_a = (m_ph[0] == 2) && (m_cnt[0] >= tgt_a);
    empty_b = (m_ph[1] == 2) && (m_cnt[1] >= tgt_b);
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic shot(input int ta, input int tb, input int p, input int pre, input bit retrig);
    bit va, vb;
    repeat (pre) @(negedge clk);
    tgt_a = ta; tgt_b = tb; got = 0;
    #1 mem_ptr = PW'(p); trig = 1;
    @(negedge clk); #1 trig = 0; mem_ptr = '0;
    if (retrig) begin
      repeat (3) @(negedge clk);
      #1 mem_ptr = PW'(p ^ 12'hFFF); trig = 1;
      @(negedge clk); #1 trig = 0; mem_ptr = '0;
    end
    repeat (TMO + 40) @(negedge clk);
    va = (ta >= MIN) && (ta <= TMO);
    vb = (tb >= MIN) && (tb <= TMO);
    if (va || vb) begin
      chk(got, "R12 strobe seen", got, 1);
      chk(g_cnt == (va ? ta : tb), va ? "R8 count from A" : "R9 count from B", g_cnt, va ? ta : tb);
      chk(g_chan == !va, va ? "R8 channel flag" : "R9 half-period flag", g_chan, !va);
      chk(g_ptr == p, "R2 pointer", g_ptr, p);
    end else begin
      chk(!got, "R10 no strobe when both invalid", got, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!charge_a && !charge_b && !drain_a && !drain_b && !res_stb, "R1 reset state",
        {charge_a, charge_b, drain_a, drain_b, res_stb}, 0);
    #1 rst_n = 1;
    shot(20, 30, 12'h123, 2, 0);        // R8 both valid
    shot(2, 30, 12'h0AB, 3, 0);         // R6 A below minimum, R9
    shot(1000, 15, 12'h3C4, 1, 0);      // R7 A times out, R9
    shot(1, 1000, 12'h055, 4, 0);       // R10 neither valid
    shot(MIN, 9, 12'h777, 6, 0);        // R6 exact minimum valid
    shot(MIN - 1, MIN, 12'h101, 7, 0);  // R6 boundary on both
    shot(0, TMO, 12'h222, 2, 0);        // R7 empty exactly at timeout
    shot(12, 7, 12'h5A5, 3, 1);         // R11 retrigger while busy ignored
    shot(3, 1000, 12'h0F0, 8, 0);       // R10 short A, timed-out B
    shot(50, 50, 12'h999, 9, 0);        // R5 long equal drains
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule